// File: doc/BRIEF.md
# Dual-Mode DMA Word Sequencer

This block is a single-channel transfer engine that copies a run of 32-bit words from a source region to a destination region. Either side can be an on-chip port, where every access takes a single cycle, or an external port whose access length in cycles is set per side. Each access is shown on the bus as a request strobe held high for the whole access. The read data is taken in on the last cycle of a read, and the write data is held steady for the whole write.

Two schedules are available. In cycle-stealing mode each word is read, then written, then followed by one idle cycle. In pipelined mode the read of the next word runs alongside the write of the current one, so in steady state a word costs only the longer of the two phases. The pipelined schedule is refused when both sides are external; such a transfer falls back to cycle-stealing. A standby request stops the engine at once, leaving the current word unfinished, and leaves an abort indication until the next start.

Top module: `dma_seq_top`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, abort_o, rd_req_o and wr_req_o are all low, and both strobes stay low whenever busy_o is low.
- R2: An access to an on-chip port holds its strobe for exactly 1 cycle. An access to an external port holds it for the programmed latency in cycles, and a programmed latency of 0 counts as 1.
- R3: In cycle-stealing mode (pipe_i = 0), successive word writes start R + W + 1 cycles apart, and read and write strobes never overlap. A transfer of N words keeps busy_o high for N*(R+W+1) - 1 cycles.
- R4: In pipelined mode with at most one external side, successive word writes start max(R, W) cycles apart, and busy_o stays high for R + (N-1)*max(R, W) + W cycles.
- R5: When both ports are external, a pipelined request runs with exactly the cycle-stealing timing of R3.
- R6: Word k is read from src + 4k and written to dst + 4k, and the data written for word k equals the data read for word k.
- R7: When the last write finishes, busy_o falls and done_o rises in the same cycle. done_o then stays high until the next accepted start.
- R8: A start with a word count of 0 raises done_o in the next cycle, leaves busy_o low and issues no strobe.
- R9: A start while busy_o is high is ignored. The transfer in progress keeps its addresses, count and timing.
- R10: A standby request while busy drops busy_o, rd_req_o and wr_req_o in the next cycle, sets abort_o and keeps done_o low. The next accepted start clears abort_o. A start is not accepted while standby_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| src_addr_i | input | AW | First source byte address |
| dst_addr_i | input | AW | First destination byte address |
| count_i | input | CW | Number of 32-bit words to move |
| pipe_i | input | 1 | 1 requests pipelined schedule, 0 cycle-stealing |
| src_ext_i | input | 1 | 1 when the source is an external port |
| dst_ext_i | input | 1 | 1 when the destination is an external port |
| src_lat_i | input | LW | Source read length in cycles when external |
| dst_lat_i | input | LW | Destination write length in cycles when external |
| standby_i | input | 1 | Standby request; aborts a running transfer |
| rd_req_o | output | 1 | Read strobe, high for every cycle of a read |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | DW | Read data, taken on the last read cycle |
| wr_req_o | output | 1 | Write strobe, high for every cycle of a write |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer completed normally |
| abort_o | output | 1 | Last transfer was stopped by standby |

## Verification
The hardest case to reach from the ports is a pipelined slot in which the read ends earlier than the write. Here the word just read has to be parked and handed to the following write, and not to the write still in progress. The stimulus reaches this case with vectors whose write is much longer than the read (1 read cycle against 5 write cycles). In those vectors the data seen on every write strobe is compared against the address-derived read pattern. Write spacing is measured by counting strobe cycles against the known access length. This separates back-to-back accesses even when a strobe never falls between words.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   localparam int unsigned WORD_BYTES = 4;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_GAP  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/dma_phase_timer.sv
// Counts the cycles of one bus access; active while cycles remain.
module dma_phase_timer #(
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          launch,
   input  logic [LW-1:0] len,
   output logic          active,
   output logic          last
);
   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (launch)         cnt_q <= len;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
   assign last   = (cnt_q == LW'(1));
endmodule

// File: rtl/dma_word_tracker.sv
// Address pointers and remaining-word counters for both sides.
module dma_word_tracker
   import dma_seq_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic [CW-1:0] count,
   input  logic          rd_issue,
   input  logic          rd_step,
   input  logic          wr_step,
   output logic [AW-1:0] rd_addr,
   output logic [AW-1:0] wr_addr,
   output logic [CW-1:0] rd_left,
   output logic          wr_final
);
   localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

   logic [CW-1:0] wr_left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr   <= '0;
         wr_addr   <= '0;
         rd_left   <= '0;
         wr_left_q <= '0;
      end else if (load) begin
         rd_addr   <= src;
         wr_addr   <= dst;
         rd_left   <= count - CW'(rd_issue);
         wr_left_q <= count;
      end else begin
         if (rd_step)  rd_addr   <= rd_addr + STEP;
         if (wr_step)  wr_addr   <= wr_addr + STEP;
         if (rd_issue) rd_left   <= rd_left - 1'b1;
         if (wr_step)  wr_left_q <= wr_left_q - 1'b1;
      end
   end

   assign wr_final = wr_step && (wr_left_q == CW'(1));
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
   import dma_seq_pkg::*;
#(
   parameter int AW         = 32,
   parameter int DW         = 32,
   parameter int CW         = 16,
   parameter int LW         = 4,
   parameter bit ALLOW_PIPE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] src_addr_i,
   input  logic [AW-1:0] dst_addr_i,
   input  logic [CW-1:0] count_i,
   input  logic          pipe_i,
   input  logic          src_ext_i,
   input  logic          dst_ext_i,
   input  logic [LW-1:0] src_lat_i,
   input  logic [LW-1:0] dst_lat_i,
   input  logic          standby_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic [DW-1:0] rd_data_i,
   output logic          wr_req_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          abort_o
);
   generate
      if (AW < 3)  begin : g_bad_aw $error("AW must be at least 3"); end
      if (DW < 8)  begin : g_bad_dw $error("DW must be at least 8"); end
      if (CW < 1)  begin : g_bad_cw $error("CW must be at least 1"); end
      if (LW < 1)  begin : g_bad_lw $error("LW must be at least 1"); end
   endgenerate

   function automatic logic [LW-1:0] eff_len(input logic ext, input logic [LW-1:0] lat);
      if (ext && (lat != '0)) return lat;
      return LW'(1);
   endfunction

   seq_state_e    state_q;
   logic          pipe_q, rd_got_q, done_q, abort_q;
   logic [LW-1:0] rlen_q, wlen_q;
   logic [DW-1:0] hold_q, wdat_q;

   logic          pipe_sel, accept, kill, slot_end;
   logic          launch_rd, launch_wr;
   logic          rd_act, rd_last, wr_act, wr_last;
   logic [LW-1:0] rd_len;
   logic [CW-1:0] rd_left;
   logic          wr_final;

   generate
      if (ALLOW_PIPE) begin : g_pipe
         assign pipe_sel = pipe_i && !(src_ext_i && dst_ext_i);
      end else begin : g_steal_only
         assign pipe_sel = 1'b0;
      end
   endgenerate

   assign accept   = start_i && (state_q == ST_IDLE) && !standby_i;
   assign kill     = standby_i && (state_q != ST_IDLE);
   assign slot_end = (state_q == ST_XFER) && (rd_act || wr_act) &&
                     (!rd_act || rd_last) && (!wr_act || wr_last);

   assign launch_wr = !kill && slot_end && (rd_last || rd_got_q);
   assign launch_rd = !kill && ((accept && (count_i != '0)) ||
                                (state_q == ST_GAP) ||
                                (slot_end && pipe_q && (rd_left != '0)));
   assign rd_len    = accept ? eff_len(src_ext_i, src_lat_i) : rlen_q;

   dma_phase_timer #(.LW(LW)) u_rd_timer (
      .clk(clk), .rst_n(rst_n), .clr(kill), .launch(launch_rd),
      .len(rd_len), .active(rd_act), .last(rd_last));

   dma_phase_timer #(.LW(LW)) u_wr_timer (
      .clk(clk), .rst_n(rst_n), .clr(kill), .launch(launch_wr),
      .len(wlen_q), .active(wr_act), .last(wr_last));

   dma_word_tracker #(.AW(AW), .CW(CW)) u_tracker (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .src(src_addr_i), .dst(dst_addr_i), .count(count_i),
      .rd_issue(launch_rd), .rd_step(rd_last), .wr_step(wr_last),
      .rd_addr(rd_addr_o), .wr_addr(wr_addr_o),
      .rd_left(rd_left), .wr_final(wr_final));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         pipe_q   <= 1'b0;
         rlen_q   <= LW'(1);
         wlen_q   <= LW'(1);
         rd_got_q <= 1'b0;
         hold_q   <= '0;
         wdat_q   <= '0;
         done_q   <= 1'b0;
         abort_q  <= 1'b0;
      end else if (kill) begin
         state_q  <= ST_IDLE;
         rd_got_q <= 1'b0;
         done_q   <= 1'b0;
         abort_q  <= 1'b1;
      end else begin
         if (accept) begin
            pipe_q  <= pipe_sel;
            rlen_q  <= eff_len(src_ext_i, src_lat_i);
            wlen_q  <= eff_len(dst_ext_i, dst_lat_i);
            abort_q <= 1'b0;
            done_q  <= (count_i == '0);
            state_q <= (count_i == '0) ? ST_IDLE : ST_XFER;
         end else if (state_q == ST_GAP) begin
            state_q <= ST_XFER;
         end else if (state_q == ST_XFER) begin
            if (wr_final) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else if (slot_end && !pipe_q && wr_last) begin
               state_q <= ST_GAP;
            end
         end

         if (rd_last) hold_q <= rd_data_i;
         if (slot_end)     rd_got_q <= 1'b0;
         else if (rd_last) rd_got_q <= 1'b1;
         if (launch_wr) wdat_q <= rd_last ? rd_data_i : hold_q;
      end
   end

   assign rd_req_o  = rd_act;
   assign wr_req_o  = wr_act;
   assign wr_data_o = wdat_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;
   assign abort_o   = abort_q;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          standby_i,
   input logic [CW-1:0] count_i,
   input logic          src_ext_i,
   input logic          dst_ext_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          abort_o,
   input logic          rd_req_o,
   input logic          wr_req_o,
   input logic          pipe_q
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!rd_req_o && !wr_req_o)); // R1

   AST_STEAL_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !pipe_q) |-> !(rd_req_o && wr_req_o)); // R3

   AST_EXT_PAIR_STEALS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !standby_i && src_ext_i && dst_ext_i) |=> !pipe_q); // R5

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i && !standby_i) |=> done_o); // R7

   AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !standby_i && (count_i == '0)) |=> (done_o && !busy_o)); // R8

   AST_STANDBY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && standby_i) |=> (!busy_o && abort_o && !done_o && !rd_req_o && !wr_req_o)); // R10
endmodule

bind dma_seq_top dma_seq_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .standby_i(standby_i),
   .count_i(count_i), .src_ext_i(src_ext_i), .dst_ext_i(dst_ext_i),
   .busy_o(busy_o), .done_o(done_o), .abort_o(abort_o),
   .rd_req_o(rd_req_o), .wr_req_o(wr_req_o), .pipe_q(pipe_q));

// File: tb/tb_dma_seq_top.sv
module tb_dma_seq_top;
   localparam int AW = 32, DW = 32, CW = 16, LW = 4;
   localparam logic [31:0] PAT = 32'h5A5A_0000;

   typedef struct packed {
      logic       pipe;
      logic       sx;
      logic       dx;
      logic [3:0] sl;
      logic [3:0] dl;
      logic [7:0] n;
      logic [7:0] per;
      logic [7:0] bsy;
   } vec_t;

   // pipe, src ext, dst ext, src lat, dst lat, words, write spacing, busy cycles
   localparam vec_t VECS [0:8] = '{
      '{1'b0, 1'b0, 1'b1, 4'd0, 4'd2, 8'd3, 8'd4, 8'd11},
      '{1'b1, 1'b0, 1'b1, 4'd0, 4'd2, 8'd3, 8'd2, 8'd7},
      '{1'b0, 1'b1, 1'b0, 4'd4, 4'd0, 8'd3, 8'd6, 8'd17},
      '{1'b1, 1'b1, 1'b0, 4'd4, 4'd0, 8'd3, 8'd4, 8'd13},
      '{1'b1, 1'b1, 1'b1, 4'd4, 4'd2, 8'd2, 8'd7, 8'd13},
      '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd4, 8'd3, 8'd11},
      '{1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 8'd4, 8'd1, 8'd5},
      '{1'b0, 1'b1, 1'b0, 4'd0, 4'd0, 8'd2, 8'd3, 8'd5},
      '{1'b1, 1'b0, 1'b1, 4'd0, 4'd5, 8'd2, 8'd5, 8'd11}
   };

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          start_i = 1'b0, pipe_i = 1'b0, src_ext_i = 1'b0, dst_ext_i = 1'b0;
   logic          standby_i = 1'b0;
   logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
   logic [CW-1:0] count_i = '0;
   logic [LW-1:0] src_lat_i = '0, dst_lat_i = '0;
   logic          rd_req_o, wr_req_o, busy_o, done_o, abort_o;
   logic [AW-1:0] rd_addr_o, wr_addr_o;
   logic [DW-1:0] rd_data_i, wr_data_o;

   int checks = 0, errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;
   assign rd_data_i = rd_addr_o ^ PAT;

   dma_seq_top #(.AW(AW), .DW(DW), .CW(CW), .LW(LW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_addr_i(src_addr_i),
      .dst_addr_i(dst_addr_i), .count_i(count_i), .pipe_i(pipe_i),
      .src_ext_i(src_ext_i), .dst_ext_i(dst_ext_i), .src_lat_i(src_lat_i),
      .dst_lat_i(dst_lat_i), .standby_i(standby_i), .rd_req_o(rd_req_o),
      .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_req_o(wr_req_o),
      .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
      .done_o(done_o), .abort_o(abort_o));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input vec_t v, input logic [31:0] src, input logic [31:0] dst);
      pipe_i = v.pipe; src_ext_i = v.sx; dst_ext_i = v.dx;
      src_lat_i = v.sl; dst_lat_i = v.dl; count_i = CW'(v.n);
      src_addr_i = src; dst_addr_i = dst; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Follows one transfer from the cycle after start until busy falls.
   task automatic follow(input vec_t v, input logic [31:0] src, input logic [31:0] dst,
                         input string req, input int pulse_at);
      int rlen, wlen, rrun, wrun, rk, wk, rtot, wtot, cyc, last_ws;
      rlen = (v.sx && v.sl != 0) ? int'(v.sl) : 1;
      wlen = (v.dx && v.dl != 0) ? int'(v.dl) : 1;
      rrun = 0; wrun = 0; rk = 0; wk = 0; rtot = 0; wtot = 0; cyc = 1; last_ws = 0;
      while (busy_o && cyc < 400) begin
         if (rd_req_o) begin
            if (rrun == 0 || rrun == rlen) begin
               chk(rd_addr_o == src + 32'(4*rk), "R6", "read address", rd_addr_o, src + 32'(4*rk));
               rk++; rrun = 1;
            end else rrun++;
            rtot++;
         end else rrun = 0;
         if (wr_req_o) begin
            if (wrun == 0 || wrun == wlen) begin
               chk(wr_addr_o == dst + 32'(4*wk), "R6", "write address", wr_addr_o, dst + 32'(4*wk));
               chk(wr_data_o == ((src + 32'(4*wk)) ^ PAT), "R6", "write data",
                   wr_data_o, (src + 32'(4*wk)) ^ PAT);
               if (wk > 0)
                  chk(cyc - last_ws == int'(v.per), req, "write spacing",
                      32'(cyc - last_ws), 32'(v.per));
               last_ws = cyc; wk++; wrun = 1;
            end else wrun++;
            wtot++;
         end else wrun = 0;
         if (cyc == pulse_at) begin
            src_addr_i = 32'hDEAD_0000; dst_addr_i = 32'hBEEF_0000;
            count_i = CW'(1); start_i = 1'b1;
         end else start_i = 1'b0;
         cyc++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(cyc - 1 == int'(v.bsy), req, "busy cycles", 32'(cyc - 1), 32'(v.bsy));
      chk(wk == int'(v.n), req, "write count", 32'(wk), 32'(v.n));
      chk(rtot == rlen * int'(v.n), "R2", "read strobe cycles", 32'(rtot), 32'(rlen * int'(v.n)));
      chk(wtot == wlen * int'(v.n), "R2", "write strobe cycles", 32'(wtot), 32'(wlen * int'(v.n)));
      chk(done_o && !abort_o, "R7", "done after last write", {30'd0, done_o, abort_o}, 32'h2);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({busy_o, done_o, abort_o, rd_req_o, wr_req_o} == 5'b0, "R1", "reset outputs",
          {27'd0, busy_o, done_o, abort_o, rd_req_o, wr_req_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rd_req_o && !wr_req_o, "R1", "idle after reset", {31'd0, busy_o}, 32'd0);

      // Table walk: R2..R6 across modes and port combinations
      for (int i = 0; i < 9; i++) begin
         logic [31:0] s, d;
         string req;
         s = 32'h1000_0000 + 32'(i * 256);
         d = 32'h2000_0000 + 32'(i * 256);
         req = VECS[i].pipe ? ((VECS[i].sx && VECS[i].dx) ? "R5" : "R4") : "R3";
         issue(VECS[i], s, d);
         follow(VECS[i], s, d, req, 0);
         @(negedge clk);
      end

      // R7: done holds while idle
      repeat (4) @(negedge clk);
      chk(done_o && !busy_o, "R7", "done held while idle", {31'd0, done_o}, 32'd1);

      // R8: zero word count
      v = '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd0, 8'd0, 8'd0};
      issue(v, 32'h3000_0000, 32'h4000_0000);
      chk(done_o && !busy_o && !rd_req_o && !wr_req_o, "R8", "zero count done",
          {29'd0, done_o, busy_o, rd_req_o | wr_req_o}, 32'h4);
      @(negedge clk);
      chk(!rd_req_o && !wr_req_o && !busy_o, "R8", "no strobe after zero count",
          {30'd0, rd_req_o, wr_req_o}, 32'd0);

      // R9: start while busy is ignored
      v = '{1'b0, 1'b0, 1'b0, 4'd0, 4'd0, 8'd3, 8'd3, 8'd8};
      issue(v, 32'h5000_0000, 32'h6000_0000);
      follow(v, 32'h5000_0000, 32'h6000_0000, "R9", 2);
      @(negedge clk);

      // R10: standby abort
      v = '{1'b0, 1'b1, 1'b0, 4'd4, 4'd0, 8'd3, 8'd6, 8'd17};
      issue(v, 32'h7000_0000, 32'h7100_0000);
      repeat (4) @(negedge clk);
      chk(busy_o, "R10", "busy before standby", {31'd0, busy_o}, 32'd1);
      standby_i = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rd_req_o && !wr_req_o, "R10", "stop on standby",
          {29'd0, busy_o, rd_req_o, wr_req_o}, 32'd0);
      chk(abort_o && !done_o, "R10", "abort set done clear", {30'd0, abort_o, done_o}, 32'h2);
      start_i = 1'b1; count_i = CW'(1);
      @(negedge clk);
      start_i = 1'b0;
      chk(!busy_o && abort_o, "R10", "start refused during standby", {30'd0, busy_o, abort_o}, 32'h1);
      repeat (2) @(negedge clk);
      chk(!rd_req_o && !wr_req_o, "R10", "quiet after abort", {30'd0, rd_req_o, wr_req_o}, 32'd0);
      standby_i = 1'b0;
      v = '{1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 8'd1, 8'd1, 8'd2};
      issue(v, 32'h7200_0000, 32'h7300_0000);
      chk(!abort_o && busy_o, "R10", "abort cleared by start", {30'd0, abort_o, busy_o}, 32'h1);
      follow(v, 32'h7200_0000, 32'h7300_0000, "R4", 0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule